// File: doc/BRIEF.md
# Per-Bit Policy Control Register

This block is one 32-bit control/status register. Each bit follows an access policy that is fixed when the design is elaborated. Parameter masks pick the policy for each bit. A bit can be read-only, write-one-to-clear, set-only (a written 0 is ignored) or clear-only (a written 1 is ignored). It can also clear when read, or be a plain read/write bit. An effective-width parameter freezes every bit above that width at its reset value.

Software uses a write strobe with data and a read strobe. The register contents are always visible on the read-data port. A read strobe clears the clear-on-read bits at the next edge, so the value seen during the read cycle is the value from before the clear. Hardware reports events through per-bit set and clear inputs. A set always wins, so an event cannot be lost to a software clear in the same cycle.

Two further masks name values that software must not write: a 1 into certain bits, or a 0 into certain others. Such a write is still applied. In addition, a one-cycle error flag and the mask of offending bits appear on the cycle after the write.

Top module: `bitpol_reg`

## Requirements
- R1: While reset is low the register holds RESET_VAL (default 32'hA500_F005), and that value is visible on rdData after reset is released.
- R2: Bits in RO_MASK (default bits 3:0) keep their value under any software write.
- R3: Bits in W1C_MASK (default bits 7:4) become 0 when written with 1 and are unchanged when written with 0.
- R4: Bits in SET_ONLY_MASK (default bits 11:8) take a written 1 and ignore a written 0.
- R5: Bits in CLR_ONLY_MASK (default bits 15:12) take a written 0 and ignore a written 1.
- R6: Bits at index WIDTH or above (default WIDTH=24) always hold their RESET_VAL bit and ignore writes and hardware inputs; WIDTH=0 means all 32 bits are live.
- R7: In-width bits with no policy (default bits 23:16, including the clear-on-read bits) take the written value.
- R8: One cycle after a write, errValid is 1 and errMask equals (wrData & BAN1_MASK) | (~wrData & BAN0_MASK) (defaults bits 21:20 and 23:22) if that mask is non-zero; otherwise errValid is 0 and errMask is 0. The write is applied normally.
- R9: rdData always shows the stored value; a read strobe clears the bits in COR_MASK (default bits 19:16) at the next edge.
- R10: A hwClr bit clears an in-width bit and a hwSet bit sets it; hwSet overrides hwClr and any software clear in the same cycle, for every in-width bit, including read-only ones.
- R11: When read and write strobes occur in the same cycle, the clear-on-read step is applied first and the write rules are then applied to its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| wrEn | input | 1 | Software write strobe |
| wrData | input | 32 | Software write value |
| rdEn | input | 1 | Software read strobe (triggers clear-on-read) |
| rdData | output | 32 | Current register contents |
| hwSet | input | 32 | Hardware per-bit set |
| hwClr | input | 32 | Hardware per-bit clear |
| errValid | output | 1 | One-cycle flag for a forbidden write |
| errMask | output | 32 | Offending bits of that write |

## Verification
All effects of the strobes and the hardware inputs are due at the first rising edge after they are driven. The new contents therefore appear on rdData, and the error flag and mask for a write appear, in the cycle after the stimulus. rdData is combinational from the stored value, so during a read cycle it shows the contents from before the clear. The bench drives inputs just after the falling edge and compares rdData during that same half-cycle against its model of the stored value. It then advances the model at the rising edge and compares the error outputs with the previous cycle's expectation at the next falling edge.

// File: rtl/bitpol_pkg.sv
package bitpol_pkg;
  localparam int RegW = 32;

  typedef struct packed {
    logic            doRead;
    logic            doWrite;
    logic [RegW-1:0] wrVal;
  } polStrobe_t;

  function automatic logic [RegW-1:0] liveMask(input int width);
    logic [RegW-1:0] m;
    int effW;
    effW = (width == 0) ? RegW : width;
    m = '0;
    for (int i = 0; i < RegW; i++) begin
      if (i < effW) m[i] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/bitpol_ctrl.sv
module bitpol_ctrl
  import bitpol_pkg::*;
#(
  parameter logic [RegW-1:0] BAN0_MASK = 32'h00C0_0000,
  parameter logic [RegW-1:0] BAN1_MASK = 32'h0030_0000
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            wrEn,
  input  logic [RegW-1:0] wrData,
  input  logic            rdEn,
  output polStrobe_t      strobe,
  output logic            errValid,
  output logic [RegW-1:0] errMask
);
  logic [RegW-1:0] violation;

  always_comb begin
    strobe.doRead  = rdEn;
    strobe.doWrite = wrEn;
    strobe.wrVal   = wrData;
    violation      = wrEn ? ((wrData & BAN1_MASK) | (~wrData & BAN0_MASK)) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errValid <= 1'b0;
      errMask  <= '0;
    end else begin
      errValid <= |violation;
      errMask  <= violation;
    end
  end
endmodule

// File: rtl/bitpol_data.sv
module bitpol_data
  import bitpol_pkg::*;
#(
  parameter int              WIDTH         = 24,
  parameter logic [RegW-1:0] RESET_VAL     = 32'hA500_F005,
  parameter logic [RegW-1:0] RO_MASK       = 32'h0000_000F,
  parameter logic [RegW-1:0] W1C_MASK      = 32'h0000_00F0,
  parameter logic [RegW-1:0] SET_ONLY_MASK = 32'h0000_0F00,
  parameter logic [RegW-1:0] CLR_ONLY_MASK = 32'h0000_F000,
  parameter logic [RegW-1:0] COR_MASK      = 32'h000F_0000
) (
  input  logic            clk,
  input  logic            rstN,
  input  polStrobe_t      strobe,
  input  logic [RegW-1:0] hwSet,
  input  logic [RegW-1:0] hwClr,
  output logic [RegW-1:0] regVal
);
  localparam logic [RegW-1:0] LiveBits  = liveMask(WIDTH);
  localparam logic [RegW-1:0] HoldOnOne = RO_MASK | W1C_MASK | CLR_ONLY_MASK;
  localparam logic [RegW-1:0] HoldOnZero = RO_MASK | W1C_MASK | SET_ONLY_MASK;

  logic [RegW-1:0] nextVal;

  for (genvar gi = 0; gi < RegW; gi++) begin : g_bit
    if (LiveBits[gi] == 1'b0) begin : g_frozen
      assign nextVal[gi] = RESET_VAL[gi];
    end else begin : g_live
      logic bitNext;
      always_comb begin
        bitNext = regVal[gi];
        if (strobe.doRead && COR_MASK[gi]) bitNext = 1'b0;
        if (strobe.doWrite) begin
          if (strobe.wrVal[gi]) begin
            if (!HoldOnOne[gi]) bitNext = 1'b1;
            if (W1C_MASK[gi])   bitNext = 1'b0;
          end else begin
            if (!HoldOnZero[gi]) bitNext = 1'b0;
          end
        end
        if (hwClr[gi]) bitNext = 1'b0;
        if (hwSet[gi]) bitNext = 1'b1;
      end
      assign nextVal[gi] = bitNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) regVal <= RESET_VAL;
    else       regVal <= nextVal;
  end
endmodule

// File: rtl/bitpol_reg.sv
module bitpol_reg
  import bitpol_pkg::*;
#(
  parameter int              WIDTH         = 24,
  parameter logic [RegW-1:0] RESET_VAL     = 32'hA500_F005,
  parameter logic [RegW-1:0] RO_MASK       = 32'h0000_000F,
  parameter logic [RegW-1:0] W1C_MASK      = 32'h0000_00F0,
  parameter logic [RegW-1:0] SET_ONLY_MASK = 32'h0000_0F00,
  parameter logic [RegW-1:0] CLR_ONLY_MASK = 32'h0000_F000,
  parameter logic [RegW-1:0] COR_MASK      = 32'h000F_0000,
  parameter logic [RegW-1:0] BAN0_MASK     = 32'h00C0_0000,
  parameter logic [RegW-1:0] BAN1_MASK     = 32'h0030_0000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [31:0] wrData,
  input  logic        rdEn,
  output logic [31:0] rdData,
  input  logic [31:0] hwSet,
  input  logic [31:0] hwClr,
  output logic        errValid,
  output logic [31:0] errMask
);
  polStrobe_t      strobe;
  logic [RegW-1:0] regVal;

  bitpol_ctrl #(
    .BAN0_MASK(BAN0_MASK),
    .BAN1_MASK(BAN1_MASK)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn),
    .strobe(strobe), .errValid(errValid), .errMask(errMask)
  );

  bitpol_data #(
    .WIDTH(WIDTH), .RESET_VAL(RESET_VAL), .RO_MASK(RO_MASK),
    .W1C_MASK(W1C_MASK), .SET_ONLY_MASK(SET_ONLY_MASK),
    .CLR_ONLY_MASK(CLR_ONLY_MASK), .COR_MASK(COR_MASK)
  ) i_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .hwSet(hwSet), .hwClr(hwClr),
    .regVal(regVal)
  );

  assign rdData = regVal;
endmodule

// File: rtl/bitpol_reg_chk.sv
module bitpol_reg_chk
  import bitpol_pkg::*;
#(
  parameter int              WIDTH     = 24,
  parameter logic [RegW-1:0] RESET_VAL = '0,
  parameter logic [RegW-1:0] RO_MASK   = '0,
  parameter logic [RegW-1:0] W1C_MASK  = '0,
  parameter logic [RegW-1:0] COR_MASK  = '0
) (
  input logic            clk,
  input logic            rstN,
  input logic            wrEn,
  input logic [RegW-1:0] wrData,
  input logic            rdEn,
  input logic [RegW-1:0] hwSet,
  input logic [RegW-1:0] hwClr,
  input logic [RegW-1:0] regVal,
  input logic            errValid,
  input logic [RegW-1:0] errMask
);
  localparam logic [RegW-1:0] LiveBits = liveMask(WIDTH);

  a_r6_frozen_bits: assert property (@(posedge clk) disable iff (!rstN)
    (regVal & ~LiveBits) == (RESET_VAL & ~LiveBits));

  a_r2_ro_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && hwSet == '0 && hwClr == '0) |=> ((regVal ^ $past(regVal)) & RO_MASK) == '0);

  a_r3_w1c_cleared: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && hwSet == '0) |=> (regVal & $past(wrData) & W1C_MASK) == '0);

  a_r9_cor_cleared: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !wrEn && hwSet == '0) |=> (regVal & COR_MASK & LiveBits) == '0);

  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    (hwSet != '0) |=> (regVal & $past(hwSet) & LiveBits) == ($past(hwSet) & LiveBits));

  a_r8_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> !errValid);

  a_r8_flag_matches_mask: assert property (@(posedge clk) disable iff (!rstN)
    errValid == (errMask != '0));
endmodule

bind bitpol_reg bitpol_reg_chk #(
  .WIDTH(WIDTH), .RESET_VAL(RESET_VAL), .RO_MASK(RO_MASK),
  .W1C_MASK(W1C_MASK), .COR_MASK(COR_MASK)
) i_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn),
  .hwSet(hwSet), .hwClr(hwClr), .regVal(regVal),
  .errValid(errValid), .errMask(errMask)
);

// File: tb/test_bitpol_reg.sv
module test_bitpol_reg;
  localparam int ClkPeriod = 10;
  localparam int Width = 24;
  localparam logic [31:0] ResetVal = 32'hA500_F005;
  localparam logic [31:0] RoM  = 32'h0000_000F;
  localparam logic [31:0] W1cM = 32'h0000_00F0;
  localparam logic [31:0] SoM  = 32'h0000_0F00;
  localparam logic [31:0] CoM  = 32'h0000_F000;
  localparam logic [31:0] CorM = 32'h000F_0000;
  localparam logic [31:0] B0M  = 32'h00C0_0000;
  localparam logic [31:0] B1M  = 32'h0030_0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [31:0] wrData = '0, hwSet = '0, hwClr = '0;
  logic [31:0] rdData, errMask;
  logic errValid;

  int checks = 0;
  int fails = 0;
  logic [31:0] model;
  logic [31:0] expErr = '0;

  always #(ClkPeriod/2) clk = ~clk;

  bitpol_reg i_bitpol_reg (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn),
    .rdData(rdData), .hwSet(hwSet), .hwClr(hwClr),
    .errValid(errValid), .errMask(errMask)
  );

  function automatic logic [31:0] nextModel(input logic [31:0] cur, input logic wr,
      input logic [31:0] wd, input logic rd, input logic [31:0] hs, input logic [31:0] hc);
    logic [31:0] n;
    for (int i = 0; i < 32; i++) begin
      logic b;
      if (i >= Width) begin
        n[i] = ResetVal[i];
      end else begin
        b = cur[i];
        if (rd && CorM[i]) b = 1'b0;
        if (wr) begin
          if (RoM[i])       b = b;
          else if (W1cM[i]) begin if (wd[i]) b = 1'b0; end
          else if (SoM[i])  begin if (wd[i]) b = 1'b1; end
          else if (CoM[i])  begin if (!wd[i]) b = 1'b0; end
          else              b = wd[i];
        end
        if (hc[i]) b = 1'b0;
        if (hs[i]) b = 1'b1;
        n[i] = b;
      end
    end
    return n;
  endfunction

  task automatic compare(input string tag, input string what, input logic [31:0] act,
      input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic op(input string tag, input logic wr, input logic [31:0] wd,
      input logic rd, input logic [31:0] hs, input logic [31:0] hc);
    @(negedge clk);
    wrEn = wr; wrData = wd; rdEn = rd; hwSet = hs; hwClr = hc;
    #1;
    compare(tag, "rdData", rdData, model);
    compare("R8", "errValid", {31'b0, errValid}, {31'b0, expErr != '0});
    compare("R8", "errMask", errMask, expErr);
    expErr = wr ? ((wd & B1M) | (~wd & B0M)) : '0;
    @(posedge clk);
    model = nextModel(model, wr, wd, rd, hs, hc);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    model = ResetVal;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R1", "rdData in reset", rdData, ResetVal);
    rstN = 1'b1;
    op("R1", 0, '0, 0, '0, '0);
    op("R2 R4 R6 R7", 1, 32'hFFFF_FFFF, 0, '0, '0);
    op("R3 R5 R7 R8", 1, 32'h0000_0000, 0, '0, '0);
    op("R10", 0, '0, 0, 32'h0F0F_00F3, '0);
    op("R3", 1, 32'h0000_0050, 0, '0, '0);
    op("R3", 1, 32'h0000_0000, 0, '0, '0);
    op("R9", 0, '0, 0, CorM, '0);
    op("R9", 0, '0, 1, '0, '0);
    op("R9", 0, '0, 0, '0, '0);
    op("R11", 0, '0, 0, CorM, '0);
    op("R11", 1, 32'h0005_0000, 1, '0, '0);
    op("R10", 1, 32'h0000_00F0, 0, 32'h0000_0030, '0);
    op("R10", 0, '0, 1, 32'h0003_0000, 32'h0003_0003);
    op("R10", 0, '0, 0, '0, 32'h0000_FFF0);
    op("R8", 1, 32'h0080_0000, 0, '0, '0);
    op("R8", 1, 32'h00F0_0000, 0, '0, '0);
    op("R6", 1, 32'h5AFF_FFFF, 0, 32'hFF00_0000, '0);
    for (int k = 0; k < 400; k++) begin
      logic [31:0] hs, hc;
      hs = (($urandom % 4) == 0) ? $urandom : '0;
      hc = (($urandom % 4) == 0) ? $urandom : '0;
      op("random", $urandom % 2, $urandom, $urandom % 2, hs, hc);
    end
    op("R8", 0, '0, 0, '0, '0);
    op("R8", 0, '0, 0, '0, '0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule